// File: doc/BRIEF.md
# Programmable AND-OR Array

This block is a small sum-of-products logic array whose connections are set by configuration bits rather than by fixed wiring. It has four external inputs. The true and the complemented form of each input are offered to every product term. Each of the four outputs ORs a fixed group of three product terms. The AND plane can be programmed; the OR plane cannot.

Output 0 (F1) is fed back into the AND plane as a fifth literal pair, true and complemented. Product terms that belong to outputs 1 to 3 can therefore use it. A function wider than three terms is built by placing part of it in F1 and finishing it in another output. The feedback is purely combinational. F1's own terms cannot see the feedback literal, so no configuration can close a loop.

The connection bits are shifted in serially while a configuration enable is high. When the enable drops after a complete load, a done flag is set and the outputs are released. Until then every output reads 0.

Top module: `pla_array`

## Requirements
- R1: After reset the done flag is 0 and all four outputs are 0.
- R2: While the done flag is 0, every output is 0 whatever the inputs are. A load of fewer than 120 bits, followed by a drop of the enable, leaves the done flag at 0.
- R3: Configuration bits are sampled on rising clock edges while `cfg_en_i` is high. The first bit of a load becomes configuration index 0 and the 120th becomes index 119. Index t*10+l connects literal l to product term t. For signal k (k = 0..3 for `in_i[k]`, k = 4 for F1), literal 2k is the true form and literal 2k+1 is the complement.
- R4: A product term with no connected literal evaluates to 1.
- R5: A product term with both a literal and its complement connected evaluates to 0.
- R6: Output j (`out_o[j]`) is the OR of product terms 3j, 3j+1 and 3j+2.
- R7: F1 (`out_o[0]`) is available to the terms of outputs 1 to 3 as literals 8 (true) and 9 (complement), with no clock delay.
- R8: Literals 8 and 9 have no effect when connected in terms 0 to 2.
- R9: With terms 0 to 2 programmed as I1·I2·I3, I2'·I3'·I4 and I1·I4 (I1..I4 = `in_i[0]..in_i[3]`), F1 matches that function for all 16 input values.
- R10: The done flag is set one clock edge after `cfg_en_i` falls, provided exactly 120 or more bits have been loaded since `cfg_en_i` last rose. A rising `cfg_en_i` clears the done flag at the next clock edge, and the outputs return to 0 from that edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the configuration logic |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_bit_i | input | 1 | Serial configuration bit |
| in_i | input | 4 | External inputs I1..I4 (bit 0 is I1) |
| cfg_done_o | output | 1 | High once a full configuration has been loaded |
| out_o | output | 4 | Array outputs; bit 0 is F1 |

## Verification
Several input patterns are used, and each tells apart a different fault:
- The all-empty configuration exposes a wrong value for an unconnected term.
- Putting a literal and its complement in the same term exposes a wrong value for a contradictory term.
- A single connected literal in an output's group pins down the bit ordering of the shift chain.
- The three-term example function is swept over all 16 inputs, with copies and inversions of F1 chained into other outputs. This separates correct feedback from a missing or delayed feedback path.
- Terms of F1 that connect the feedback literal show whether that connection is properly ignored.
- Sparse random configurations, each swept over all 16 inputs, are checked against a bench model. They catch faults in the plane indexing.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int unsigned NUM_IN   = 4;
  localparam int unsigned NUM_OUT  = 4;
  localparam int unsigned TERMS_PO = 3;
  localparam int unsigned NUM_SIG  = NUM_IN + 1;
  localparam int unsigned NUM_LIT  = 2 * NUM_SIG;
  localparam int unsigned NUM_TERM = NUM_OUT * TERMS_PO;
  localparam int unsigned CFG_BITS = NUM_TERM * NUM_LIT;
endpackage

// File: rtl/pla_cfg_loader.sv
module pla_cfg_loader #(
  parameter int unsigned CFG_BITS = 120
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_en_i,
  input  logic                cfg_bit_i,
  output logic [CFG_BITS-1:0] cfg_o,
  output logic                done_o
);
  localparam int unsigned CW = $clog2(CFG_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(CFG_BITS);

  logic [CFG_BITS-1:0] shift_q;
  logic [CW-1:0]       cnt_q;
  logic                en_q;
  logic                done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      en_q <= cfg_en_i;
      if (cfg_en_i) begin
        // first bit in walks down to index 0 after a full load
        shift_q <= {cfg_bit_i, shift_q[CFG_BITS-1:1]};
        done_q  <= 1'b0;
        if (!en_q)              cnt_q <= CW'(1);
        else if (cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
      end else begin
        done_q <= (cnt_q == FULL);
      end
    end
  end

  assign cfg_o  = shift_q;
  assign done_o = done_q;
endmodule

// File: rtl/pla_term.sv
module pla_term #(
  parameter int unsigned NUM_LIT = 10
) (
  input  logic [NUM_LIT-1:0] lit_i,
  input  logic [NUM_LIT-1:0] conn_i,
  output logic               term_o
);
  // unconnected literals read as 1; empty term gives 1
  assign term_o = &(lit_i | ~conn_i);
endmodule

// File: rtl/pla_or_group.sv
module pla_or_group #(
  parameter int unsigned TERMS_PO = 3
) (
  input  logic [TERMS_PO-1:0] term_i,
  output logic                y_o
);
  assign y_o = |term_i;
endmodule

// File: rtl/pla_array.sv
module pla_array
  import pla_pkg::*;
#(
  parameter int unsigned N_IN  = NUM_IN,
  parameter int unsigned N_OUT = NUM_OUT,
  parameter int unsigned TPO   = TERMS_PO
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_bit_i,
  input  logic [N_IN-1:0]  in_i,
  output logic             cfg_done_o,
  output logic [N_OUT-1:0] out_o
);
  localparam int unsigned N_SIG   = N_IN + 1;
  localparam int unsigned N_LIT   = 2 * N_SIG;
  localparam int unsigned N_TERM  = N_OUT * TPO;
  localparam int unsigned N_HI    = N_TERM - TPO;
  localparam int unsigned N_CFG   = N_TERM * N_LIT;
  localparam logic [N_LIT-1:0] FB_MASK = {2'b11, {(N_LIT-2){1'b0}}};

  logic [N_CFG-1:0] cfg;
  logic [N_LIT-1:0] lit_pri;
  logic [N_LIT-1:0] lit_full;
  logic [TPO-1:0]   term_lo;
  logic [N_HI-1:0]  term_hi;
  logic             f_fb;
  logic [N_OUT-1:0] out_raw;

  pla_cfg_loader #(.CFG_BITS(N_CFG)) u_load (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_en_i (cfg_en_i),
    .cfg_bit_i(cfg_bit_i),
    .cfg_o    (cfg),
    .done_o   (cfg_done_o)
  );

  for (genvar k = 0; k < N_IN; k++) begin : g_lit
    assign lit_pri[2*k]    = in_i[k];
    assign lit_pri[2*k+1]  = ~in_i[k];
    assign lit_full[2*k]   = in_i[k];
    assign lit_full[2*k+1] = ~in_i[k];
  end
  // feedback literal pair; absent from the primary vector
  assign lit_pri[N_LIT-2]  = 1'b0;
  assign lit_pri[N_LIT-1]  = 1'b0;
  assign lit_full[N_LIT-2] = f_fb;
  assign lit_full[N_LIT-1] = ~f_fb;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    if (t < TPO) begin : g_src
      pla_term #(.NUM_LIT(N_LIT)) u_term (
        .lit_i (lit_pri),
        .conn_i(cfg[t*N_LIT +: N_LIT] & ~FB_MASK),
        .term_o(term_lo[t])
      );
    end else begin : g_use
      pla_term #(.NUM_LIT(N_LIT)) u_term (
        .lit_i (lit_full),
        .conn_i(cfg[t*N_LIT +: N_LIT]),
        .term_o(term_hi[t-TPO])
      );
    end
  end

  pla_or_group #(.TERMS_PO(TPO)) u_or_fb (
    .term_i(term_lo),
    .y_o   (f_fb)
  );
  assign out_raw[0] = f_fb;

  for (genvar j = 1; j < N_OUT; j++) begin : g_or
    pla_or_group #(.TERMS_PO(TPO)) u_or (
      .term_i(term_hi[(j-1)*TPO +: TPO]),
      .y_o   (out_raw[j])
    );
  end

  assign out_o = cfg_done_o ? out_raw : '0;
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int unsigned N_OUT = 4,
  parameter int unsigned TPO   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_en_i,
  input logic             cfg_done_o,
  input logic [N_OUT-1:0] out_o,
  input logic [TPO-1:0]   term_lo
);
  // R2
  gated_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_o |-> (out_o == '0));

  // R10
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |=> !cfg_done_o);

  // R10
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_done_o) |-> !$past(cfg_en_i));

  // R6
  or_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_o && (|term_lo)) |-> out_o[0]);

  // R6
  or_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_o && !(|term_lo)) |-> !out_o[0]);
endmodule

bind pla_array pla_array_chk #(.N_OUT(N_OUT), .TPO(TPO)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_en_i  (cfg_en_i),
  .cfg_done_o(cfg_done_o),
  .out_o     (out_o),
  .term_lo   (term_lo)
);

// File: tb/sim_pla_array.sv
module sim_pla_array;
  localparam int NB = 120;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_en_i;
  logic       cfg_bit_i;
  logic [3:0] in_i;
  logic       cfg_done_o;
  logic [3:0] out_o;

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk_i = ~clk_i;

  pla_array u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cfg_bit_i(cfg_bit_i),
    .in_i(in_i), .cfg_done_o(cfg_done_o), .out_o(out_o)
  );

  function automatic logic [3:0] ref_eval(input logic [NB-1:0] c, input logic [3:0] x);
    logic [9:0] lit;
    logic [3:0] y;
    logic p;
    y = '0;
    for (int k = 0; k < 4; k++) begin
      lit[2*k] = x[k];
      lit[2*k+1] = ~x[k];
    end
    lit[9:8] = 2'b00;
    for (int t = 0; t < 3; t++) begin
      p = 1'b1;
      for (int l = 0; l < 8; l++) if (c[t*10+l]) p = p & lit[l];
      y[0] = y[0] | p;
    end
    lit[8] = y[0];
    lit[9] = ~y[0];
    for (int t = 3; t < 12; t++) begin
      p = 1'b1;
      for (int l = 0; l < 10; l++) if (c[t*10+l]) p = p & lit[l];
      y[t/3] = y[t/3] | p;
    end
    return y;
  endfunction

  function automatic logic [NB-1:0] con(input logic [NB-1:0] c, input int t, input int l);
    logic [NB-1:0] r;
    r = c;
    r[t*10+l] = 1'b1;
    return r;
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic load(input logic [NB-1:0] c, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk_i);
      cfg_en_i = 1'b1;
      cfg_bit_i = c[i];
    end
    @(negedge clk_i);
    cfg_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic sweep(input string req, input logic [NB-1:0] c);
    for (int v = 0; v < 16; v++) begin
      in_i = 4'(v);
      #1;
      check(req, {cfg_done_o, out_o}, {1'b1, ref_eval(c, 4'(v))});
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!ended) begin
      n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] c;
    logic [NB-1:0] ex;
    logic f;
    void'($urandom(32'd4242));
    rst_ni = 1'b0; cfg_en_i = 1'b0; cfg_bit_i = 1'b0; in_i = 4'h0;
    #18 rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check("R1", {cfg_done_o, out_o}, 5'b0);

    // R2: short load stays unreleased
    load({NB{1'b1}} ^ {60{2'b01}}, 50);
    for (int v = 0; v < 4; v++) begin
      in_i = 4'($urandom);
      #1;
      check("R2", {cfg_done_o, out_o}, 5'b0);
    end

    // R4: empty configuration -> every term 1
    load('0, NB);
    sweep("R4", '0);

    // R5: I1 and its complement in every term
    c = '0;
    for (int t = 0; t < 12; t++) c = con(con(c, t, 0), t, 1);
    load(c, NB);
    sweep("R5", c);

    // R3: single literal per group checks index order
    c = '0;
    for (int t = 0; t < 12; t++) if (t % 3 != 0) c = con(con(c, t, 0), t, 1);
    c = con(c, 0, 7);   // out0 = ~I4
    c = con(c, 3, 2);   // out1 = I2
    c = con(c, 6, 5);   // out2 = ~I3
    c = con(c, 9, 0);   // out3 = I1
    load(c, NB);
    for (int v = 0; v < 16; v++) begin
      in_i = 4'(v);
      #1;
      check("R3", {cfg_done_o, out_o},
            {1'b1, in_i[0], ~in_i[2], in_i[1], ~in_i[3]});
    end

    // R9 / R7: example function chained into outputs 1 and 2
    ex = '0;
    ex = con(con(con(ex, 0, 0), 0, 2), 0, 4);
    ex = con(con(con(ex, 1, 3), 1, 5), 1, 6);
    ex = con(con(ex, 2, 0), 2, 6);
    ex = con(ex, 3, 8);
    ex = con(con(ex, 4, 0), 4, 1);
    ex = con(con(ex, 5, 0), 5, 1);
    ex = con(ex, 6, 9);
    ex = con(con(ex, 7, 2), 7, 3);
    ex = con(con(ex, 8, 2), 8, 3);
    load(ex, NB);
    for (int v = 0; v < 16; v++) begin
      in_i = 4'(v);
      f = (in_i[0] & in_i[1] & in_i[2]) | (~in_i[1] & ~in_i[2] & in_i[3]) | (in_i[0] & in_i[3]);
      #1;
      check("R9", {cfg_done_o, out_o[0]}, {1'b1, f});
      check("R7", {cfg_done_o, out_o}, {1'b1, 1'b1, ~f, f, f});
    end

    // R10: raising enable clears done and zeroes outputs
    in_i = 4'hF;
    @(negedge clk_i);
    cfg_en_i = 1'b1; cfg_bit_i = 1'b0;
    @(negedge clk_i);
    #1;
    check("R10", {cfg_done_o, out_o}, 5'b0);
    cfg_en_i = 1'b0;
    @(negedge clk_i);
    #1;
    check("R10", {cfg_done_o, out_o}, 5'b0);

    // R8: feedback in F1's own terms ignored
    c = '0;
    c = con(c, 0, 8);
    c = con(c, 1, 9);
    c = con(con(c, 2, 0), 2, 1);
    load(c, NB);
    sweep("R8", c);

    // R6: sparse random configurations against the model
    for (int r = 0; r < 8; r++) begin
      c = '0;
      for (int i = 0; i < NB; i++) c[i] = ($urandom_range(0, 5) == 0);
      load(c, NB);
      sweep("R6", c);
    end

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule